// File: doc/BRIEF.md
# Contact Image Sensor Timing Adapter

This block connects an imaging front end, which produces a pixel-rate reset strobe and a line-transfer pulse, to a contact image sensor that takes a single clock and a shift-in signal. The sensor clock is taken from the reset strobe, whose duty cycle is below one half. The transfer pulse is stretched into the shift-in signal, so that shift-in stays asserted until the first reset pulse after the transfer has ended and that pulse has fallen.

Such a sensor has no dark pixels at the start of a line. The adapter can create some by holding the sensor clock high for a programmed number of reset pulses, starting at the first rising edge of the strobe after each transfer. While the clock is held high the sensor output is forced to zero, and only one real image pixel is lost. A status flag marks that window. All inputs are sampled on the system clock. Strobe edges are found by comparing each sample with the one before it.

Top module: `cis_timing_adapter`

## Requirements
- R1: A synchronous active-high reset drives `sensor_clk`, `shift_in` and `black_flag` low in the cycle after the reset edge and removes any pending or active black window.
- R2: Outside a black window, `sensor_clk` equals `rs_strobe` delayed by exactly two system clocks (one input sample stage and one output register).
- R3: A black window opens on the first rising edge of the sampled strobe after the sampled transfer pulse has ended. From then on `sensor_clk` stays high without a break until the falling edge of the Nth strobe pulse, where N is the value of `black_len` and the opening pulse counts as pulse 1.
- R4: `shift_in` rises two system clocks after `xfer_pulse` rises. It stays high while the transfer pulse is high, and falls with the falling edge of the first strobe pulse that rises after the transfer pulse has ended. That fall shows at the output two clocks after the strobe falls.
- R5: No black window opens if `black_len` is 0 or `black_en` is low at the strobe edge that would open it; `sensor_clk` then passes the strobe through.
- R6: `black_flag` is high in exactly the cycles in which `sensor_clk` is forced high by a window.
- R7: A transfer pulse that arrives during an open window closes it at once and rearms it, so that a new window of full length opens at the next strobe rising edge after the transfer.
- R8: The window length is captured when the window opens. A change to `black_len` during an open window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_strobe | input | 1 | Pixel-rate reset strobe from the front end |
| xfer_pulse | input | 1 | Line-transfer pulse from the front end |
| black_len | input | 5 | Number of strobe pulses to hold the sensor clock high (0 = off) |
| black_en | input | 1 | Allows black-pixel insertion |
| sensor_clk | output | 1 | Clock to the sensor |
| shift_in | output | 1 | Stretched transfer pulse to the sensor's shift-in |
| black_flag | output | 1 | High while the sensor clock is forced high |

## Verification
The assertions check on every cycle that the flag never appears without a high sensor clock, that an open window's pulse count stays between one and its captured length, that a transfer always sets shift-in and closes any window, and that a disabled or zero-length setting never opens one. Only the bench's scenarios can show the exact two-clock latency of the pass-through, the cycle in which shift-in falls, and that a window ends on the falling edge of the right pulse. The same holds for a length change during a window and for a restart caused by a transfer mid-window. The bench compares all three outputs with its reference model on every clock.

// File: rtl/cis_pkg.sv
package cis_pkg;
  localparam int unsigned LEN_W = 5;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_t;
endpackage

// File: rtl/cis_edge_sampler.sv
module cis_edge_sampler
  import cis_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rs_raw,
  input  logic    xfer_raw,
  output strobe_t rs_ev,
  output logic    xfer_lvl
);
  logic rs_now_q;
  logic rs_old_q;
  logic xfer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_now_q <= 1'b0;
      rs_old_q <= 1'b0;
      xfer_q   <= 1'b0;
    end else begin
      rs_now_q <= rs_raw;
      rs_old_q <= rs_now_q;
      xfer_q   <= xfer_raw;
    end
  end

  always_comb begin
    rs_ev.level = rs_now_q;
    rs_ev.rise  = rs_now_q & ~rs_old_q;
    rs_ev.fall  = ~rs_now_q & rs_old_q;
  end

  assign xfer_lvl = xfer_q;
endmodule

// File: rtl/cis_si_stretch.sv
module cis_si_stretch
  import cis_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    xfer_lvl,
  input  strobe_t rs_ev,
  output logic    si_q
);
  logic pulse_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      si_q         <= 1'b0;
      pulse_seen_q <= 1'b0;
    end else if (xfer_lvl) begin
      si_q         <= 1'b1;
      pulse_seen_q <= 1'b0;
    end else if (si_q && pulse_seen_q && rs_ev.fall) begin
      si_q         <= 1'b0;
      pulse_seen_q <= 1'b0;
    end else if (si_q && rs_ev.rise) begin
      pulse_seen_q <= 1'b1;
    end
  end

  assert_xfer_sets_si_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_lvl |=> si_q);

  assert_si_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (si_q && !xfer_lvl && !rs_ev.fall) |=> si_q);
endmodule

// File: rtl/cis_black_window.sv
module cis_black_window
  import cis_pkg::*;
#(
  parameter int unsigned CNT_W = LEN_W
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_lvl,
  input  strobe_t          rs_ev,
  input  logic             ins_en,
  input  logic [CNT_W-1:0] ins_len,
  output logic             win_q,
  output logic             win_nxt
);
  logic             armed_q, armed_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] lim_q, lim_nxt;
  logic             len_ok;

  assign len_ok = ins_en && (ins_len != '0);

  always_comb begin
    armed_nxt = armed_q;
    win_nxt   = win_q;
    cnt_nxt   = cnt_q;
    lim_nxt   = lim_q;
    if (xfer_lvl) begin
      armed_nxt = 1'b1;
      win_nxt   = 1'b0;
      cnt_nxt   = '0;
    end else if (armed_q && rs_ev.rise) begin
      armed_nxt = 1'b0;
      if (len_ok) begin
        win_nxt = 1'b1;
        cnt_nxt = {{(CNT_W-1){1'b0}}, 1'b1};
        lim_nxt = ins_len;
      end
    end else if (win_q) begin
      if (rs_ev.rise) begin
        cnt_nxt = cnt_q + 1'b1;
      end else if (rs_ev.fall && (cnt_q == lim_q)) begin
        win_nxt = 1'b0;
        cnt_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      win_q   <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      armed_q <= armed_nxt;
      win_q   <= win_nxt;
      cnt_q   <= cnt_nxt;
      lim_q   <= lim_nxt;
    end
  end

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    win_q |-> (cnt_q >= 1 && cnt_q <= lim_q));

  assert_disabled_no_window_R5: assert property (@(posedge clk) disable iff (rst)
    (armed_q && rs_ev.rise && !xfer_lvl && !len_ok) |=> !win_q);

  assert_xfer_rearms_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_lvl |=> (!win_q && armed_q));

  assert_length_held_R8: assert property (@(posedge clk) disable iff (rst)
    (win_q && win_nxt && !xfer_lvl) |=> $stable(lim_q));
endmodule

// File: rtl/cis_timing_adapter.sv
module cis_timing_adapter
  import cis_pkg::*;
#(
  parameter int unsigned CNT_W = LEN_W
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             rs_strobe,
  input  logic             xfer_pulse,
  input  logic [CNT_W-1:0] black_len,
  input  logic             black_en,
  output logic             sensor_clk,
  output logic             shift_in,
  output logic             black_flag
);
  strobe_t rs_ev;
  logic    xfer_lvl;
  logic    win_q, win_nxt;
  logic    si_q;
  logic    sclk_q;

  cis_edge_sampler u_sampler (
    .clk      (clk),
    .rst      (rst),
    .rs_raw   (rs_strobe),
    .xfer_raw (xfer_pulse),
    .rs_ev    (rs_ev),
    .xfer_lvl (xfer_lvl)
  );

  cis_si_stretch u_stretch (
    .clk      (clk),
    .rst      (rst),
    .xfer_lvl (xfer_lvl),
    .rs_ev    (rs_ev),
    .si_q     (si_q)
  );

  cis_black_window #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .xfer_lvl (xfer_lvl),
    .rs_ev    (rs_ev),
    .ins_en   (black_en),
    .ins_len  (black_len),
    .win_q    (win_q),
    .win_nxt  (win_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= rs_ev.level | win_nxt;
  end

  assign sensor_clk = sclk_q;
  assign shift_in   = si_q;
  assign black_flag = win_q;

  assert_flag_implies_clk_R6: assert property (@(posedge clk) disable iff (rst)
    black_flag |-> sensor_clk);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!sensor_clk && !shift_in && !black_flag));
endmodule

// File: tb/test_cis_timing_adapter.sv
module test_cis_timing_adapter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rs = 1'b0;
  logic       tr = 1'b0;
  logic [4:0] blen = 5'd10;
  logic       ben = 1'b1;
  logic       sclk, si, blk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string scen = "R1";

  always #2 clk = ~clk;

  cis_timing_adapter i_cis_timing_adapter (
    .clk(clk), .rst(rst), .rs_strobe(rs), .xfer_pulse(tr),
    .black_len(blen), .black_en(ben),
    .sensor_clk(sclk), .shift_in(si), .black_flag(blk)
  );

  // reference model: behavioural, in terms of the requirements
  int m_smp = 0, m_prev = 0, m_tr = 0;
  int m_pend = 0, m_open = 0, m_pulses = 0, m_len = 0;
  int m_si = 0, m_seen = 0;
  int e_sclk = 0, e_si = 0, e_blk = 0;

  always @(posedge clk) begin
    int up, dn;
    if (rst) begin
      m_smp = 0; m_prev = 0; m_tr = 0; m_pend = 0; m_open = 0;
      m_pulses = 0; m_len = 0; m_si = 0; m_seen = 0;
      e_sclk = 0; e_si = 0; e_blk = 0;
    end else begin
      up = (m_smp == 1 && m_prev == 0);
      dn = (m_smp == 0 && m_prev == 1);
      if (m_tr == 1) begin
        m_si = 1; m_seen = 0; m_pend = 1; m_open = 0; m_pulses = 0;
      end else begin
        if (m_si == 1 && m_seen == 1 && dn) begin m_si = 0; m_seen = 0; end
        else if (m_si == 1 && up) m_seen = 1;
        if (m_pend == 1 && up) begin
          m_pend = 0;
          if (ben && blen != 0) begin m_open = 1; m_pulses = 1; m_len = blen; end
        end else if (m_open == 1) begin
          if (up) m_pulses++;
          else if (dn && m_pulses == m_len) m_open = 0;
        end
      end
      e_sclk = (m_open == 1 || m_smp == 1) ? 1 : 0;
      e_si   = m_si;
      e_blk  = m_open;
      m_prev = m_smp; m_smp = rs; m_tr = tr;
    end
  end

  task automatic check(string req, logic act, int exp);
    checks++;
    if (act !== exp[0]) begin
      fails++;
      $display("FAIL %s (%s) at cycle %0d: actual %0b expected %0d", req, scen, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(e_blk ? "R3" : "R2", sclk, e_sclk);
      check("R4", si, e_si);
      check("R6", blk, e_blk);
    end
  end

  task automatic pixels(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      rs = 1'b1; repeat (hi) @(negedge clk);
      rs = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic xfer(int len);
    tr = 1'b1; repeat (len) @(negedge clk);
    tr = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic line(int npix, int hi, int lo);
    xfer(3);
    pixels(npix, hi, lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    scen = "R1";
    check("R1", sclk, 0); check("R1", si, 0); check("R1", blk, 0);

    scen = "R2"; pixels(6, 2, 3);
    scen = "R3"; blen = 5'd10; ben = 1'b1; line(16, 2, 4);
    scen = "R3"; line(14, 3, 3);
    scen = "R3"; blen = 5'd1; line(6, 1, 2);
    scen = "R3"; blen = 5'd31; line(34, 1, 2);
    scen = "R5"; blen = 5'd0; line(8, 2, 3);
    scen = "R5"; blen = 5'd7; ben = 1'b0; line(8, 2, 3);
    ben = 1'b1;
    scen = "R7"; blen = 5'd8; xfer(2); pixels(3, 2, 3); xfer(4); pixels(12, 2, 3);
    scen = "R8"; blen = 5'd6; xfer(2); pixels(2, 2, 3); blen = 5'd2; pixels(8, 2, 3);
    scen = "R4"; blen = 5'd3; tr = 1'b1; rs = 1'b1; repeat (4) @(negedge clk);
    rs = 1'b0; repeat (2) @(negedge clk); tr = 1'b0; repeat (2) @(negedge clk);
    pixels(6, 2, 2);

    // R1: reset in the middle of a window
    scen = "R1"; blen = 5'd12; xfer(2); pixels(3, 2, 3);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    check("R1", sclk, 0); check("R1", si, 0); check("R1", blk, 0);
    rst = 1'b0; pixels(5, 2, 3);
    check("R1", blk, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule